// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Channel

This block is the transmit half of a serial port. Software writes one data byte into a holding buffer. When the output shifter is free, the byte moves into the shifter and the buffer is released for the next byte. A software-visible control byte holds four things: an enable bit, a two-bit clock-source select, and two read-only flags. One flag reports an empty holding buffer. The other reports that the channel is busy, either sending or holding data.

Bit timing comes from two stages. A prescaler takes the bus clock undivided, or divided by 8, 32 or 256. A reload down-counter then divides that stream again and emits one baud tick each time it underflows. Each serial bit lasts `TICKS_PER_BIT` ticks. The frame format is fixed: one low start bit, the data bits sent LSB first, and one high stop bit. The line idles high.

Clearing the enable bit stops an ongoing frame at once, discards any byte still waiting in the buffer, and forces the flags back to their idle reading.

Top module: `stx_channel`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0x12 and `txd` is high. Control byte layout: bit 0 is enable, bit 1 is buffer-empty, bit 2 is busy, bits 5:4 are the clock-source select, and bits 3, 6 and 7 read 0.
- R2: A control write loads enable from bit 0 and the source select from bits 5:4. The written values of bits 1, 2, 3, 6 and 7 have no effect on what is read back.
- R3: A buffer write while enabled makes buffer-empty read 0 and busy read 1 on the next cycle.
- R4: While disabled, a buffer write changes no flag, and its data is never transmitted, even after enable is set later.
- R5: When the buffer is full, the shifter is idle and enable is 1, the byte moves to the shifter in one cycle and buffer-empty returns to 1. A buffer write made during a frame keeps buffer-empty at 0 until that frame ends.
- R6: Busy returns to 0 once the shifter has finished and the buffer is empty. While the buffer holds data, busy reads 1.
- R7: Each frame is a 0 start bit, DATA_W data bits LSB first, and a 1 stop bit. Every bit lasts TICKS_PER_BIT × (baud_reload + 1) × D clock cycles. Transmission begins on the baud tick after the byte moves into the shifter.
- R8: Source select 0, 1, 2 and 3 gives D = 1, 8, 32 and 256.
- R9: A control write that clears enable forces `txd` high, buffer-empty to 1 and busy to 0 on the next cycle. A byte still waiting in the buffer is dropped.
- R10: Two bytes written back to back go out as two consecutive frames in write order, and no frame appears without a matching write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write value |
| ctrl_rdata | output | 8 | Control byte read value |
| buf_wr | input | 1 | Holding buffer write strobe |
| buf_wdata | input | DATA_W | Byte to transmit |
| baud_reload | input | RELOAD_W | Reload value of the baud down-counter |
| txd | output | 1 | Serial output, idles high |

## Verification
The bench builds the channel with `TICKS_PER_BIT` = 2, `DATA_W` = 8 and `RELOAD_W` = 8. The short bit length lets the bench run a full frame at every prescaler setting, up to divide-by-256, in a few thousand cycles. Driving `baud_reload` between 0 and 3 gives bit times from 8 to 512 cycles. At these bit times, a wrong divider or a wrong reload count shifts the monitor's mid-bit samples onto the wrong bits. The same short frames also keep a disable issued mid-frame, and the byte waiting behind it, within a compact run.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_EMPTY_BIT = 1;
    localparam int CTRL_BUSY_BIT  = 2;
    localparam int CTRL_SEL_LO    = 4;
    localparam int CTRL_SEL_HI    = 5;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_ARMED = 2'd1,
        SH_SEND  = 2'd2
    } sh_state_e;

    typedef struct packed {
        logic       en;
        logic [1:0] sel;
        logic       empty;
        logic       busy;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{en: 1'b0, sel: 2'b01, empty: 1'b1, busy: 1'b0};

    // Low-bit mask of the free-running prescaler count for each source select
    function automatic logic [7:0] src_mask(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8'h00;
            2'd1:    return 8'h07;
            2'd2:    return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/stx_prescale.sv
module stx_prescale
    import stx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       pulse
);

    localparam int CNT_W = 8;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + 1'b1 : '0;
        pulse = run && (&(cnt_q | ~src_mask(sel)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/stx_baud.sv
module stx_baud #(
    parameter int RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                src_pulse,
    input  logic [RELOAD_W-1:0] reload,
    output logic                tick
);

    logic [RELOAD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = reload;
        end else if (src_pulse) begin
            if (cnt_q == '0) begin
                tick  = 1'b1;
                cnt_d = reload;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
    import stx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              tick,
    output logic              idle,
    output logic              txd
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int TC_W    = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int BL_W    = $clog2(FRAME_W + 1);

    typedef struct packed {
        sh_state_e          st;
        logic [FRAME_W-1:0] sreg;
        logic [DATA_W-1:0]  hold;
        logic [TC_W-1:0]    tcnt;
        logic [BL_W-1:0]    left;
        logic               txd;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (abort) begin
            sh_d.st   = SH_IDLE;
            sh_d.txd  = 1'b1;
            sh_d.tcnt = '0;
        end else begin
            case (sh_q.st)
                SH_IDLE: begin
                    if (load) begin
                        sh_d.hold = load_data;
                        sh_d.st   = SH_ARMED;
                    end
                end
                SH_ARMED: begin
                    if (tick) begin
                        sh_d.sreg = {1'b1, sh_q.hold, 1'b0};
                        sh_d.st   = SH_SEND;
                        sh_d.left = BL_W'(FRAME_W);
                        sh_d.tcnt = '0;
                        sh_d.txd  = 1'b0;
                    end
                end
                SH_SEND: begin
                    if (tick) begin
                        if (sh_q.tcnt == TC_W'(TICKS_PER_BIT - 1)) begin
                            sh_d.tcnt = '0;
                            if (sh_q.left == BL_W'(1)) begin
                                sh_d.st  = SH_IDLE;
                                sh_d.txd = 1'b1;
                            end else begin
                                sh_d.sreg = {1'b1, sh_q.sreg[FRAME_W-1:1]};
                                sh_d.left = sh_q.left - 1'b1;
                                sh_d.txd  = sh_q.sreg[1];
                            end
                        end else begin
                            sh_d.tcnt = sh_q.tcnt + 1'b1;
                        end
                    end
                end
                default: sh_d.st = SH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '{st: SH_IDLE, sreg: '0, hold: '0, tcnt: '0, left: '0, txd: 1'b1};
        else        sh_q <= sh_d;
    end

    assign idle = (sh_q.st == SH_IDLE);
    assign txd  = sh_q.txd;

    // R5: the controller hands over a byte only when the shifter is free
    assert_load_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (sh_q.st == SH_IDLE));

endmodule

// File: rtl/stx_channel.sv
module stx_channel
    import stx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    parameter int RELOAD_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic [7:0]          ctrl_wdata,
    output logic [7:0]          ctrl_rdata,
    input  logic                buf_wr,
    input  logic [DATA_W-1:0]   buf_wdata,
    input  logic [RELOAD_W-1:0] baud_reload,
    output logic                txd
);

    ctrl_t             c_d, c_q;
    logic [DATA_W-1:0] buf_d, buf_q;
    logic              abort, buf_accept, load;
    logic              sh_idle, src_pulse, tick;
    logic              unused_wbits;

    assign unused_wbits = ^{ctrl_wdata[7:6], ctrl_wdata[3:1]};

    always_comb begin
        c_d        = c_q;
        buf_d      = buf_q;
        load       = 1'b0;
        abort      = ctrl_wr && !ctrl_wdata[CTRL_EN_BIT];
        buf_accept = buf_wr && c_q.en && !abort;
        if (ctrl_wr) begin
            c_d.en  = ctrl_wdata[CTRL_EN_BIT];
            c_d.sel = ctrl_wdata[CTRL_SEL_HI:CTRL_SEL_LO];
        end
        if (abort) begin
            c_d.empty = 1'b1;
            c_d.busy  = 1'b0;
        end else if (c_q.en) begin
            if (!c_q.empty && sh_idle) begin
                load      = 1'b1;
                c_d.empty = 1'b1;
            end
            if (buf_accept) begin
                buf_d     = buf_wdata;
                c_d.empty = 1'b0;
                c_d.busy  = 1'b1;
            end else if (sh_idle && c_q.empty) begin
                c_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q   <= CTRL_RESET;
            buf_q <= '0;
        end else begin
            c_q   <= c_d;
            buf_q <= buf_d;
        end
    end

    always_comb begin
        ctrl_rdata                          = '0;
        ctrl_rdata[CTRL_EN_BIT]             = c_q.en;
        ctrl_rdata[CTRL_EMPTY_BIT]          = c_q.empty;
        ctrl_rdata[CTRL_BUSY_BIT]           = c_q.busy;
        ctrl_rdata[CTRL_SEL_HI:CTRL_SEL_LO] = c_q.sel;
    end

    stx_prescale u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (c_q.en),
        .sel   (c_q.sel),
        .pulse (src_pulse)
    );

    stx_baud #(.RELOAD_W(RELOAD_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (c_q.en),
        .src_pulse (src_pulse),
        .reload    (baud_reload),
        .tick      (tick)
    );

    stx_shifter #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (abort || !c_q.en),
        .load      (load),
        .load_data (buf_q),
        .tick      (tick),
        .idle      (sh_idle),
        .txd       (txd)
    );

    // R3: an accepted buffer write marks the buffer full and the channel busy
    assert_write_sets_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && c_q.en && !(ctrl_wr && !ctrl_wdata[CTRL_EN_BIT])) |=> (!c_q.empty && c_q.busy));

    // R6: a full buffer always reads as busy
    assert_full_implies_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.empty |-> c_q.busy);

    // R9: clearing enable returns the line and the flags to idle on the next cycle
    assert_abort_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_wdata[CTRL_EN_BIT]) |=> (c_q.empty && !c_q.busy && txd));

    // R4: with the channel disabled, only a control write can change the control byte
    assert_disabled_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_q.en && !ctrl_wr) |=> $stable(ctrl_rdata));

endmodule

// File: tb/stx_channel_bench.sv
module stx_channel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int TPB        = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_wr = 1'b0;
    logic [7:0]    ctrl_wdata = '0;
    logic [7:0]    ctrl_rdata;
    logic          buf_wr = 1'b0;
    logic [DW-1:0] buf_wdata = '0;
    logic [7:0]    baud_reload = 8'd3;
    logic          txd;

    int            checks = 0;
    int            failures = 0;
    int            bit_cyc = 8;
    bit            mon_on = 1'b1;
    bit            done = 1'b0;
    logic [DW-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    stx_channel #(.DATA_W(DW), .TICKS_PER_BIT(TPB), .RELOAD_W(8)) u_stx_channel (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wdata  (ctrl_wdata),
        .ctrl_rdata  (ctrl_rdata),
        .buf_wr      (buf_wr),
        .buf_wdata   (buf_wdata),
        .baud_reload (baud_reload),
        .txd         (txd)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic [7:0] v);
        @(negedge clk);
        ctrl_wr    = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr    = 1'b0;
    endtask

    task automatic buf_write(input logic [DW-1:0] v, input bit expect_frame);
        @(negedge clk);
        buf_wr    = 1'b1;
        buf_wdata = v;
        if (expect_frame) exp_q.push_back(v);
        @(negedge clk);
        buf_wr    = 1'b0;
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
    endtask

    // Monitor: decodes frames at mid-bit and compares against the scoreboard queue (R7, R10)
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && rst_n && txd == 1'b0) begin
                logic [DW-1:0] got;
                logic          startb, stopb;
                logic [DW-1:0] want;
                repeat (bit_cyc/2 - 1) @(negedge clk);
                startb = txd;
                for (int i = 0; i < DW; i++) begin
                    repeat (bit_cyc) @(negedge clk);
                    got[i] = txd;
                end
                repeat (bit_cyc) @(negedge clk);
                stopb = txd;
                chk(startb == 1'b0 && stopb == 1'b1, "R7 start/stop", {30'd0, startb, stopb}, 32'h1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected frame", got, 32'h0);
                end else begin
                    want = exp_q.pop_front();
                    chk(got == want, "R7/R8 frame data", got, want);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lows;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset value and idle line
        chk(ctrl_rdata == 8'h12, "R1 reset ctrl", ctrl_rdata, 8'h12);
        chk(txd == 1'b1, "R1 reset txd", txd, 1);

        // R2: reserved and read-only bits written as 1 have no effect
        ctrl_write(8'b1111_1110);
        chk(ctrl_rdata == 8'h32, "R2 ctrl write sel=3", ctrl_rdata, 8'h32);
        ctrl_write(8'h00);
        chk(ctrl_rdata == 8'h02, "R2 ctrl write sel=0", ctrl_rdata, 8'h02);

        // R4: buffer write while disabled is ignored and never sent
        baud_reload = 8'd3;
        bit_cyc     = TPB * 4 * 1;
        buf_write(8'hA5, 1'b0);
        chk(ctrl_rdata == 8'h02, "R4 flags unchanged", ctrl_rdata, 8'h02);
        ctrl_write(8'h01);
        chk(ctrl_rdata == 8'h03, "R2 enable set", ctrl_rdata, 8'h03);
        count_low(150, lows);
        chk(lows == 0, "R4 no frame after enable", lows, 0);

        // R3, R5, R6: single frame
        buf_write(8'h3C, 1'b1);
        chk(ctrl_rdata == 8'h05, "R3 write sets flags", ctrl_rdata, 8'h05);
        @(negedge clk);
        chk(ctrl_rdata == 8'h07, "R5 transfer empties buffer", ctrl_rdata, 8'h07);
        repeat (120) @(negedge clk);
        chk(ctrl_rdata == 8'h03, "R6 busy cleared", ctrl_rdata, 8'h03);

        // R5, R10: double buffering, back-to-back frames
        buf_write(8'h81, 1'b1);
        @(negedge clk);
        buf_write(8'h5A, 1'b1);
        chk(ctrl_rdata == 8'h05, "R5 second byte held", ctrl_rdata, 8'h05);
        repeat (40) @(negedge clk);
        chk(ctrl_rdata == 8'h05, "R5 buffer full during frame", ctrl_rdata, 8'h05);
        repeat (250) @(negedge clk);
        chk(ctrl_rdata == 8'h03, "R6 busy cleared after pair", ctrl_rdata, 8'h03);

        // R8: other prescaler selections
        baud_reload = 8'd1;
        bit_cyc     = TPB * 2 * 8;
        ctrl_write(8'h11);
        buf_write(8'hC3, 1'b1);
        repeat (400) @(negedge clk);
        chk(ctrl_rdata == 8'h13, "R8 div8 done", ctrl_rdata, 8'h13);

        baud_reload = 8'd0;
        bit_cyc     = TPB * 1 * 32;
        ctrl_write(8'h21);
        buf_write(8'h96, 1'b1);
        repeat (750) @(negedge clk);
        chk(ctrl_rdata == 8'h23, "R8 div32 done", ctrl_rdata, 8'h23);

        bit_cyc = TPB * 1 * 256;
        ctrl_write(8'h31);
        buf_write(8'h4B, 1'b1);
        repeat (5600) @(negedge clk);
        chk(ctrl_rdata == 8'h33, "R8 div256 done", ctrl_rdata, 8'h33);

        // R9: disable mid-frame with a byte waiting
        baud_reload = 8'd3;
        bit_cyc     = TPB * 4 * 1;
        ctrl_write(8'h01);
        mon_on = 1'b0;
        buf_write(8'hF0, 1'b0);
        repeat (3) @(negedge clk);
        buf_write(8'h0F, 1'b0);
        count_low(30, lows);
        chk(lows > 0, "R9 frame was running", lows, 1);
        ctrl_write(8'h00);
        chk(ctrl_rdata == 8'h02, "R9 flags after disable", ctrl_rdata, 8'h02);
        chk(txd == 1'b1, "R9 line high after disable", txd, 1);
        count_low(150, lows);
        chk(lows == 0, "R9 line stays high", lows, 0);
        ctrl_write(8'h01);
        count_low(150, lows);
        chk(lows == 0, "R9 waiting byte dropped", lows, 0);
        mon_on = 1'b1;

        chk(exp_q.size() == 0, "R10 all frames seen", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule